// File: doc/BRIEF.md
# Indirect CSR Window Translator

This block sits between the core's indirect CSR access path and the register bank of a core-local interrupt controller. Each access carries a 12-bit select index, a small register number, a read/write strobe and a 32-bit write word. The block decodes the select index into one of three windows and turns the access into a bank-side transaction.

In the byte window, one 32-bit word stands for one byte of each of four consecutive interrupts, either the control byte or the attribute byte. In the flag window, one word holds 32 pending bits or 32 enable bits. In the trigger window, the word is forwarded unchanged to a word-wide port. The configuration slot and every invalid combination read as zero and never write. A read returns its data one cycle after the strobe.

The register bank keeps the per-interrupt storage and its acceptance policy. A pending-bit write aimed at a level-triggered source is still passed through, and the bank decides whether to take it. Interrupt numbers at or above the configured count are masked in both directions.

Top module: `irq_csr_window`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `rsp_rdata` is 0.
- R2: For a select of 0x000 to 0x3FF with register number 0, a write drives all four byte lanes in the same cycle. Lane k (k = 0..3) addresses byte (select×4+k)×4+2 of the bank and carries bits 8k+7..8k of the write word.
- R3: Register number 1 in the byte window uses the same lanes at byte offset +3 (the attribute byte) instead of +2.
- R4: A read in the byte window returns, in bits 8k+7..8k, the bank byte of interrupt select×4+k. The lowest-numbered interrupt is in the lowest byte.
- R5: A lane whose interrupt number is NUM_IRQ or higher raises no write enable, and its byte reads as 0.
- R6: For a select of 0x400 to 0x47F, register number 0 accesses pending flags and register number 1 accesses enable flags (`flag_pick` 0 or 1). Bit i of the word belongs to interrupt (select−0x400)×32+i, and the group number (select−0x400) appears on `flag_grp`.
- R7: Flags of interrupts at NUM_IRQ or above are left out of `flag_wmask` and read as 0. A group with no valid interrupt raises no `flag_we`.
- R8: For a select of 0x480 to 0x49F with register number 0, reads and writes go to `word_addr` = 0x40 + (select−0x480).
- R9: Select 0x4A0 is reserved. A read there returns 0, and a write there strobes no bank port.
- R10: A register number above 1, a select above 0x4A0, or register number 1 at a select of 0x480 or above strobes no bank port, and a read returns 0.
- R11: A read strobe is followed by `rsp_valid` and its data on exactly the next cycle. Writes produce no response. At most one bank port is strobed per cycle, in the strobe cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 12 | Indirect select index |
| req_reg | input | REG_W | Register number within the select |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Read data valid, one cycle after the read strobe |
| rsp_rdata | output | 32 | Registered read word |
| byte_we | output | 4 | Per-lane byte write enables |
| byte_addr | output | 4*BAW | Four lane byte addresses, lane 0 lowest (BAW = clog2(NUM_IRQ)+2) |
| byte_wdata | output | 32 | Lane write bytes |
| byte_rdata | input | 32 | Lane read bytes returned by the bank in the same cycle |
| flag_we | output | 1 | Flag group write strobe |
| flag_pick | output | 1 | 0 = pending flags, 1 = enable flags |
| flag_grp | output | 7 | Group of 32 interrupts |
| flag_wmask | output | 32 | Flags that exist and may be written |
| flag_wdata | output | 32 | Flag write values |
| flag_rdata | input | 32 | Flag group read value from the bank |
| word_we | output | 1 | Trigger word write strobe |
| word_addr | output | 8 | Trigger word byte offset |
| word_wdata | output | 32 | Trigger write word |
| word_rdata | input | 32 | Trigger read word from the bank |

## Verification
The assertions assume that the bank returns `byte_rdata`, `flag_rdata` and `word_rdata` combinationally in the same cycle as the addresses, and that the request fields are free of unknowns whenever `req_valid` is high. The stimulus changes requests only on the falling clock edge. It holds each request for exactly one rising edge and leaves an idle cycle between accesses. The bench bank model answers out-of-range flag indices with ones and unused byte lanes with a nonzero byte, so a missing mask in the block shows up in the read data.

// File: rtl/irqwin_pkg.sv
package irqwin_pkg;
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_BYTE = 2'd1,
      WIN_FLAG = 2'd2,
      WIN_WORD = 2'd3
   } win_kind_e;

   localparam int unsigned SEL_W       = 12;
   localparam int unsigned DATA_W      = 32;
   localparam int unsigned LANES       = DATA_W / 8;
   localparam int unsigned GRP_W       = 7;
   localparam int unsigned WADDR_W     = 8;
   localparam logic [SEL_W-1:0] SEL_FLAG_LO = 12'h400;
   localparam logic [SEL_W-1:0] SEL_WORD_LO = 12'h480;
   localparam logic [SEL_W-1:0] SEL_CFG     = 12'h4A0;
   localparam logic [WADDR_W-1:0] WORD_BASE = 8'h40;
endpackage

// File: rtl/irqwin_decode.sv
module irqwin_decode
   import irqwin_pkg::*;
#(
   parameter int unsigned REG_W = 2
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic [REG_W-1:0]   regno,
   output win_kind_e          kind,
   output logic               second,
   output logic [GRP_W-1:0]   grp,
   output logic [WADDR_W-1:0] woff
);
   logic reg_ok;
   logic [SEL_W-1:0] flag_rel;
   logic [SEL_W-1:0] word_rel;

   assign reg_ok   = (regno == REG_W'(0)) || (regno == REG_W'(1));
   assign second   = (regno == REG_W'(1));
   assign flag_rel = sel - SEL_FLAG_LO;
   assign word_rel = sel - SEL_WORD_LO;
   assign grp      = flag_rel[GRP_W-1:0];
   assign woff     = WORD_BASE + {3'b000, word_rel[4:0]};

   always_comb begin
      kind = WIN_NONE;
      if (reg_ok) begin
         if (sel < SEL_FLAG_LO) begin
            kind = WIN_BYTE;
         end else if (sel < SEL_WORD_LO) begin
            kind = WIN_FLAG;
         end else if ((sel < SEL_CFG) && !second) begin
            kind = WIN_WORD;
         end
      end
   end
endmodule

// File: rtl/irqwin_lanes.sv
module irqwin_lanes
   import irqwin_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 64,
   parameter int unsigned BAW     = 8
) (
   input  logic                 active,
   input  logic                 wr,
   input  logic [SEL_W-1:0]     sel,
   input  logic                 attr,
   input  logic [DATA_W-1:0]    bank_rd,
   output logic [LANES-1:0]     we,
   output logic [LANES*BAW-1:0] addr,
   output logic [DATA_W-1:0]    rword
);
   localparam int unsigned IRQ_W = SEL_W + 2;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [IRQ_W-1:0] irq;
      logic             in_range;
      assign irq      = {sel, 2'(k)};
      assign in_range = irq < IRQ_W'(NUM_IRQ);
      assign we[k]    = active && wr && in_range;
      assign addr[k*BAW +: BAW] = in_range ? BAW'({irq, 1'b1, attr}) : '0;
      assign rword[8*k +: 8]    = (active && in_range) ? bank_rd[8*k +: 8] : 8'h00;
   end
endmodule

// File: rtl/irqwin_flags.sv
module irqwin_flags
   import irqwin_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 64
) (
   input  logic              active,
   input  logic              wr,
   input  logic [GRP_W-1:0]  grp,
   input  logic [DATA_W-1:0] bank_rd,
   output logic [DATA_W-1:0] wmask,
   output logic              we,
   output logic [DATA_W-1:0] rword
);
   localparam int unsigned IDX_W = GRP_W + 6;

   for (genvar i = 0; i < DATA_W; i++) begin : g_flag
      logic [IDX_W-1:0] idx;
      assign idx      = {1'b0, grp, 5'(i)};
      assign wmask[i] = active && (idx < IDX_W'(NUM_IRQ));
      assign rword[i] = wmask[i] && bank_rd[i];
   end

   assign we = active && wr && (|wmask);
endmodule

// File: rtl/irq_csr_window.sv
module irq_csr_window
   import irqwin_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 64,
   parameter int unsigned REG_W   = 2,
   localparam int unsigned BAW    = $clog2(NUM_IRQ) + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [11:0]          req_sel,
   input  logic [REG_W-1:0]     req_reg,
   input  logic [31:0]          req_wdata,
   output logic                 rsp_valid,
   output logic [31:0]          rsp_rdata,
   output logic [3:0]           byte_we,
   output logic [4*BAW-1:0]     byte_addr,
   output logic [31:0]          byte_wdata,
   input  logic [31:0]          byte_rdata,
   output logic                 flag_we,
   output logic                 flag_pick,
   output logic [6:0]           flag_grp,
   output logic [31:0]          flag_wmask,
   output logic [31:0]          flag_wdata,
   input  logic [31:0]          flag_rdata,
   output logic                 word_we,
   output logic [7:0]           word_addr,
   output logic [31:0]          word_wdata,
   input  logic [31:0]          word_rdata
);
   if ((NUM_IRQ < 2) || (NUM_IRQ > 4096)) begin : g_bad_count
      $error("irq_csr_window: NUM_IRQ must lie in 2..4096");
   end
   if ((REG_W < 1) || (REG_W > 8)) begin : g_bad_regw
      $error("irq_csr_window: REG_W must lie in 1..8");
   end

   win_kind_e          kind;
   logic               second;
   logic [GRP_W-1:0]   grp;
   logic [WADDR_W-1:0] woff;
   logic [DATA_W-1:0]  byte_word;
   logic [DATA_W-1:0]  flag_word;
   logic [DATA_W-1:0]  rd_mux;
   logic               is_read;

   irqwin_decode #(.REG_W(REG_W)) u_decode (
      .sel   (req_sel),
      .regno (req_reg),
      .kind  (kind),
      .second(second),
      .grp   (grp),
      .woff  (woff)
   );

   irqwin_lanes #(.NUM_IRQ(NUM_IRQ), .BAW(BAW)) u_lanes (
      .active (req_valid && (kind == WIN_BYTE)),
      .wr     (req_write),
      .sel    (req_sel),
      .attr   (second),
      .bank_rd(byte_rdata),
      .we     (byte_we),
      .addr   (byte_addr),
      .rword  (byte_word)
   );

   irqwin_flags #(.NUM_IRQ(NUM_IRQ)) u_flags (
      .active (req_valid && (kind == WIN_FLAG)),
      .wr     (req_write),
      .grp    (grp),
      .bank_rd(flag_rdata),
      .wmask  (flag_wmask),
      .we     (flag_we),
      .rword  (flag_word)
   );

   assign byte_wdata = req_wdata;
   assign flag_wdata = req_wdata;
   assign word_wdata = req_wdata;
   assign flag_pick  = second;
   assign flag_grp   = grp;
   assign word_addr  = woff;
   assign word_we    = req_valid && req_write && (kind == WIN_WORD);
   assign is_read    = req_valid && !req_write;

   always_comb begin
      unique case (kind)
         WIN_BYTE: rd_mux = byte_word;
         WIN_FLAG: rd_mux = flag_word;
         WIN_WORD: rd_mux = word_rdata;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= is_read;
         if (is_read) begin
            rsp_rdata <= rd_mux;
         end
      end
   end
endmodule

// File: rtl/irq_csr_window_chk.sv
module irq_csr_window_chk #(
   parameter int unsigned NUM_IRQ = 64,
   parameter int unsigned REG_W   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic [11:0]      req_sel,
   input logic [REG_W-1:0] req_reg,
   input logic             rsp_valid,
   input logic [31:0]      rsp_rdata,
   input logic [3:0]       byte_we,
   input logic             flag_we,
   input logic [6:0]       flag_grp,
   input logic [31:0]      flag_wmask,
   input logic             word_we
);
   logic any_we;
   assign any_we = (|byte_we) || flag_we || word_we;

   assert_read_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);
   assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);
   assert_one_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({|byte_we, flag_we, word_we}));
   assert_byte_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|byte_we) |-> (req_valid && req_write && (req_sel < 12'h400)));
   assert_lane_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      byte_we[3] |-> ({req_sel, 2'b11} < 14'(NUM_IRQ)));
   assert_flag_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (req_valid && req_write && (req_sel >= 12'h400) && (req_sel < 12'h480)));
   assert_flag_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (flag_wmask[0] && ({1'b0, flag_grp, 5'd0} < 13'(NUM_IRQ))));
   assert_word_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      word_we |-> ((req_sel >= 12'h480) && (req_sel < 12'h4A0) && (req_reg == REG_W'(0))));
   assert_cfg_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_sel == 12'h4A0)) |-> !any_we);
   assert_cfg_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && (req_sel == 12'h4A0)) |=> (rsp_rdata == 32'h0));
   assert_bad_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_reg > REG_W'(1))) |-> !any_we);
   assert_high_sel_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && (req_sel > 12'h4A0)) |=> (rsp_rdata == 32'h0));
endmodule

bind irq_csr_window irq_csr_window_chk #(.NUM_IRQ(NUM_IRQ), .REG_W(REG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_sel   (req_sel),
   .req_reg   (req_reg),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .byte_we   (byte_we),
   .flag_we   (flag_we),
   .flag_grp  (flag_grp),
   .flag_wmask(flag_wmask),
   .word_we   (word_we)
);

// File: tb/irq_csr_window_test.sv
module irq_csr_window_test;
   localparam int CLK_PERIOD = 10;
   localparam int NIRQ       = 62;
   localparam int REGW       = 2;
   localparam int BAW        = $clog2(NIRQ) + 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_write = 1'b0;
   logic [11:0]     req_sel = '0;
   logic [REGW-1:0] req_reg = '0;
   logic [31:0]     req_wdata = '0;
   logic            rsp_valid;
   logic [31:0]     rsp_rdata;
   logic [3:0]      byte_we;
   logic [4*BAW-1:0] byte_addr;
   logic [31:0]     byte_wdata;
   logic [31:0]     byte_rdata;
   logic            flag_we;
   logic            flag_pick;
   logic [6:0]      flag_grp;
   logic [31:0]     flag_wmask;
   logic [31:0]     flag_wdata;
   logic [31:0]     flag_rdata;
   logic            word_we;
   logic [7:0]      word_addr;
   logic [31:0]     word_wdata;
   logic [31:0]     word_rdata;

   int checks = 0;
   int errors = 0;
   int nstrobe = 0;
   bit done = 1'b0;

   logic [7:0]  bmem [0:NIRQ*4-1];
   logic        pend [0:NIRQ-1];
   logic        en   [0:NIRQ-1];
   logic [31:0] wmem [0:255];

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_csr_window #(.NUM_IRQ(NIRQ), .REG_W(REGW)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
      .req_reg(req_reg), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .byte_we(byte_we), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
      .byte_rdata(byte_rdata),
      .flag_we(flag_we), .flag_pick(flag_pick), .flag_grp(flag_grp),
      .flag_wmask(flag_wmask), .flag_wdata(flag_wdata), .flag_rdata(flag_rdata),
      .word_we(word_we), .word_addr(word_addr), .word_wdata(word_wdata),
      .word_rdata(word_rdata)
   );

   function automatic logic [7:0] bpre(input int a);
      return 8'((a * 7) + 3);
   endfunction

   function automatic logic ppre(input int i);
      return logic'(((i & 1) != 0) ^ ((i & 4) != 0));
   endfunction

   // bank model: combinational reads, writes on the rising edge
   always_comb begin
      for (int k = 0; k < 4; k++) begin
         int a;
         a = int'(byte_addr[k*BAW +: BAW]);
         byte_rdata[8*k +: 8] = (a < NIRQ*4) ? bmem[a] : 8'hEE;
      end
      for (int i = 0; i < 32; i++) begin
         int idx;
         idx = int'(flag_grp) * 32 + i;
         if (idx < NIRQ) flag_rdata[i] = flag_pick ? en[idx] : pend[idx];
         else            flag_rdata[i] = 1'b1;
      end
      word_rdata = wmem[word_addr];
   end

   always @(posedge clk) begin
      if (|byte_we || flag_we || word_we) nstrobe = nstrobe + 1;
      for (int k = 0; k < 4; k++) begin
         if (byte_we[k]) bmem[int'(byte_addr[k*BAW +: BAW])] <= byte_wdata[8*k +: 8];
      end
      if (flag_we) begin
         for (int i = 0; i < 32; i++) begin
            int idx;
            idx = int'(flag_grp) * 32 + i;
            if (flag_wmask[i] && idx < NIRQ) begin
               if (flag_pick) en[idx] <= flag_wdata[i];
               else           pend[idx] <= flag_wdata[i];
            end
         end
      end
      if (word_we) wmem[word_addr] <= word_wdata;
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a response appears
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rsp_rdata !== e) begin
               errors++;
               $display("FAIL %s read actual=%h expected=%h", t, rsp_rdata, e);
            end
         end
      end
   end

   task automatic drive(input logic [11:0] sel, input logic [REGW-1:0] r,
                        input logic wr, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_sel   = sel;
      req_reg   = r;
      req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic csr_wr(input logic [11:0] sel, input logic [REGW-1:0] r, input logic [31:0] d);
      drive(sel, r, 1'b1, d);
   endtask

   task automatic csr_rd(input logic [11:0] sel, input logic [REGW-1:0] r,
                         input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      drive(sel, r, 1'b0, 32'h0);
      chk({31'b0, rsp_valid}, 32'd1, "R11 response one cycle after strobe");
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] e;
      int s0;
      for (int a = 0; a < NIRQ*4; a++) bmem[a] = bpre(a);
      for (int i = 0; i < NIRQ; i++) begin
         pend[i] = ppre(i);
         en[i]   = 1'b0;
      end
      for (int a = 0; a < 256; a++) wmem[a] = 32'h0;
      wmem[8'h5F] = 32'h12345678;
      wmem[8'h60] = 32'hCAFEF00D;

      repeat (3) @(negedge clk);
      chk({31'b0, rsp_valid}, 32'd0, "R1 rsp_valid in reset");
      chk(rsp_rdata, 32'h0, "R1 rsp_rdata in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk({31'b0, rsp_valid}, 32'd0, "R1 rsp_valid after reset");

      // R2: control bytes of interrupts 8..11
      csr_wr(12'h002, 2'd0, 32'hA1B2C3D4);
      chk({rsp_valid, 23'b0, bmem[34]}, {1'b0, 23'b0, 8'hD4}, "R2 lane0 irq8 ctrl, R11 no write response");
      chk({bmem[47], bmem[42], bmem[38]}, {bpre(47), 8'hB2, 8'hC3}, "R2 lanes 1,2 and attr untouched");
      chk({24'b0, bmem[46]}, 32'h000000A1, "R2 lane3 irq11 ctrl");
      // R3: attribute bytes
      csr_wr(12'h002, 2'd1, 32'h11223344);
      chk({bmem[35], bmem[39], bmem[43], bmem[47]}, 32'h44332211, "R3 attribute lanes");
      chk({24'b0, bmem[34]}, 32'h000000D4, "R3 control byte kept");
      // R4: reads
      csr_rd(12'h002, 2'd0, 32'hA1B2C3D4, "R4 ctrl word");
      csr_rd(12'h002, 2'd1, 32'h11223344, "R4 attr word");
      e = {bpre(23*4+2), bpre(22*4+2), bpre(21*4+2), bpre(20*4+2)};
      csr_rd(12'h005, 2'd0, e, "R4 preloaded irq20..23");
      // R5: partial last group (irqs 60..63, only 60,61 exist)
      csr_wr(12'h00F, 2'd0, 32'hFFFFFFFF);
      chk({16'b0, bmem[61*4+2], bmem[60*4+2]}, 32'h0000FFFF, "R5 valid lanes written");
      chk({24'b0, bmem[0]}, {24'b0, bpre(0)}, "R5 masked lanes wrote nothing");
      csr_rd(12'h00F, 2'd0, 32'h0000FFFF, "R5 masked lanes read zero");
      s0 = nstrobe;
      csr_wr(12'h010, 2'd0, 32'h55555555);
      chk(32'(nstrobe - s0), 32'd0, "R5 fully out-of-range group no strobe");
      csr_rd(12'h010, 2'd0, 32'h0, "R5 out-of-range read zero");

      // R6: flag window
      csr_wr(12'h400, 2'd0, 32'h80000001);
      chk({29'b0, pend[0], pend[1], pend[31]}, 32'd5, "R6 pending bits 0,1,31");
      csr_rd(12'h400, 2'd0, 32'h80000001, "R6 pending read");
      csr_wr(12'h400, 2'd1, 32'h0000F0F0);
      csr_rd(12'h400, 2'd1, 32'h0000F0F0, "R6 enable read");
      // R7: group 1 holds irqs 32..61
      e = 32'h0;
      for (int i = 0; i < 30; i++) e[i] = ppre(32 + i);
      csr_rd(12'h401, 2'd0, e, "R7 pending high group masked");
      csr_wr(12'h401, 2'd1, 32'hFFFFFFFF);
      chk({30'b0, en[61], en[31]}, 32'd2, "R7 enable 61 set, 31 kept");
      csr_rd(12'h401, 2'd1, 32'h3FFFFFFF, "R7 enable top bits zero");
      s0 = nstrobe;
      csr_wr(12'h402, 2'd0, 32'hFFFFFFFF);
      chk(32'(nstrobe - s0), 32'd0, "R7 empty group no strobe");
      csr_rd(12'h402, 2'd0, 32'h0, "R7 empty group reads zero");

      // R8: trigger words
      csr_wr(12'h485, 2'd0, 32'hDEADBEEF);
      chk(wmem[8'h45], 32'hDEADBEEF, "R8 trigger write offset");
      csr_rd(12'h485, 2'd0, 32'hDEADBEEF, "R8 trigger read");
      csr_rd(12'h49F, 2'd0, 32'h12345678, "R8 last trigger word");

      // R9: configuration slot
      s0 = nstrobe;
      csr_wr(12'h4A0, 2'd0, 32'h0000007F);
      chk(32'(nstrobe - s0), 32'd0, "R9 reserved write no strobe");
      chk(wmem[8'h60], 32'hCAFEF00D, "R9 neighbour word untouched");
      csr_rd(12'h4A0, 2'd0, 32'h0, "R9 reserved read");

      // R10: ignored combinations
      s0 = nstrobe;
      csr_wr(12'h002, 2'd2, 32'h00000000);
      csr_wr(12'h4A1, 2'd0, 32'hFFFFFFFF);
      csr_wr(12'h485, 2'd1, 32'h0BADF00D);
      chk(32'(nstrobe - s0), 32'd0, "R10 ignored writes no strobe");
      chk({bmem[34], 24'b0}, {8'hD4, 24'b0}, "R10 bad register number kept byte");
      chk(wmem[8'h45], 32'hDEADBEEF, "R10 reg1 trigger write ignored");
      csr_rd(12'h002, 2'd3, 32'h0, "R10 bad register number read");
      csr_rd(12'h4A1, 2'd0, 32'h0, "R10 select above config read");
      csr_rd(12'h485, 2'd1, 32'h0, "R10 reg1 in trigger range read");

      repeat (3) @(negedge clk);
      chk(32'(exp_q.size()), 32'd0, "R11 all responses delivered");
      summary();
   end
endmodule